// File: doc/BRIEF.md
# Paddle Ball Game Engine

This block runs the motion rules of a single-paddle bounce game on a 640 by 480 pixel field. A frame tick arrives once per video frame (60 Hz in normal use). A pointing device supplies the horizontal paddle position, and a start button launches play. The block keeps the ball position, one direction bit per axis, the play phase and a pointer to the brick row currently at the top of the field. A separate drawing engine uses the outputs to render the scene: the ball and paddle coordinates, a one-cycle brick-clear request naming the row and the half to erase, and a game-over flag.

The ball is a 5x5 square and the paddle is a 50 by 5 bar whose top edge lies at row 450. Before play starts, the ball sits centred on the paddle. Once released, the ball moves one pixel on each axis per tick. It reflects off the side walls, the top edge and the paddle. If the ball falls past the paddle, play ends and everything freezes until a synchronous reset.

Top module: `bounce_engine`

## Requirements
- R1: One cycle after the synchronous reset `rst` is released, the block is in the idle phase. `game_over` and `clr_req` are 0, `ball_y` is 445, and `ball_x` equals `paddle_x` + 25.
- R2: While idle, `ball_x` follows `paddle_x` + 25 with one cycle of latency, `ball_y` stays at 445, and frame ticks do not move the ball. `paddle_pos` always shows `paddle_x` registered by one cycle.
- R3: A cycle with `start_btn` high in the idle phase starts play. The first tick afterwards moves the ball to x+1, y-1 (rightward and upward).
- R4: During play, each `frame_tick` cycle changes `ball_x` and `ball_y` by exactly one pixel each: x rises when the horizontal direction is right and falls otherwise, and y rises when the vertical direction is down and falls otherwise. Without a tick the ball does not move.
- R5: On a tick with `ball_x` above 635, the horizontal direction becomes left before the step. On a tick with `ball_x` equal to 0, it becomes right before the step. In both cases the step is taken in the new direction.
- R6: On a tick with `ball_y` equal to 0, the vertical direction becomes down, so `ball_y` becomes 1 on that tick.
- R7: Each top hit drives `clr_req` high for exactly one cycle. `clr_row` carries the brick-row pointer value from before the hit, and `clr_half` is 1 when `ball_x` was at least 320 (right half) and 0 otherwise (left half). The pointer starts at NUM_ROWS-1 (3 by default) and drops by one on each top hit, staying at 0 once it reaches 0.
- R8: On a tick where the ball is falling with `ball_y` at least 445, and `paddle_x` <= `ball_x` <= `paddle_x` + 50 (both ends included), the vertical direction becomes up and `ball_y` is held at 445 while `ball_x` still steps.
- R9: If the paddle test of R8 fails on such a tick, `game_over` goes to 1 on that tick. From then on the ball does not move and `start_btn` has no effect.
- R10: A synchronous reset taken after game over returns the block to the idle phase of R1, and play can then start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle pulse per frame; advances the ball |
| paddle_x | input | COORD_W | Left edge of the paddle from the pointing device |
| start_btn | input | 1 | Launches the ball while idle |
| ball_x | output | COORD_W | Ball left-edge x coordinate |
| ball_y | output | COORD_W | Ball top-edge y coordinate |
| paddle_pos | output | COORD_W | Registered paddle x coordinate |
| clr_req | output | 1 | One-cycle brick-clear request |
| clr_row | output | ROW_W | Brick row to clear |
| clr_half | output | 1 | Half to clear: 0 left, 1 right |
| game_over | output | 1 | Ball missed the paddle; play frozen |

## Verification
Properties are checked on every cycle:
- a brick-clear pulse lasts one cycle and appears only when the ball has just left the top edge;
- the ball stays still between ticks and after game over;
- every tick during play moves x by one pixel in the direction now held;
- the idle ball rests at row 445;
- x never passes 636.

Only the bench's scenarios can show the following:
- the paddle window decision at both inclusive edges and one pixel outside;
- the row-pointer sequence down to saturation;
- the half-select on both sides of the field;
- exact wall and top timing;
- idle tracking;
- that start is ignored after a miss;
- recovery through reset.

// File: rtl/bounce_pkg.sv
`timescale 1ns/1ps
package bounce_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_OVER = 2'd2
   } phase_t;
endpackage

// File: rtl/bounce_axis.sv
`timescale 1ns/1ps
// One coordinate with its direction bit. It bounces at a low limit and,
// when HAS_CEIL is set, at a high limit. An outside park command sends it
// to a fixed position and points it in the PARK_DIR direction.
module bounce_axis #(
   parameter int W        = 10,
   parameter bit HAS_CEIL = 1'b1,
   parameter int CEIL     = 635,
   parameter int FLOOR    = 1,
   parameter int PARK     = 0,
   parameter bit PARK_DIR = 1'b0,
   parameter int RST_POS  = 0,
   parameter bit RST_DIR  = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_pos,
   input  logic         load_dir,
   input  logic         park,
   input  logic         step,
   output logic [W-1:0] pos,
   output logic         dir
);
   localparam logic [W-1:0] CEIL_V  = W'(CEIL);
   localparam logic [W-1:0] FLOOR_V = W'(FLOOR);
   localparam logic [W-1:0] PARK_V  = W'(PARK);
   localparam logic [W-1:0] RST_V   = W'(RST_POS);
   localparam logic [W-1:0] ONE     = W'(1);

   logic ceil_hit;
   logic next_dir;

   generate
      if (HAS_CEIL) begin : g_ceil
         always_comb ceil_hit = (pos > CEIL_V);
      end else begin : g_open
         always_comb ceil_hit = 1'b0;
      end
   endgenerate

   // the reflection is decided before the step, so the step follows the new direction
   always_comb begin
      if (ceil_hit)             next_dir = 1'b0;
      else if (pos < FLOOR_V)   next_dir = 1'b1;
      else                      next_dir = dir;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos <= RST_V;
         dir <= RST_DIR;
      end else if (load) begin
         pos <= load_pos;
         dir <= load_dir;
      end else if (park) begin
         pos <= PARK_V;
         dir <= PARK_DIR;
      end else if (step) begin
         pos <= next_dir ? pos + ONE : pos - ONE;
         dir <= next_dir;
      end
   end
endmodule

// File: rtl/brick_row_tracker.sv
`timescale 1ns/1ps
// Holds the index of the brick row now at the top of the field. On each
// top hit it sends a one-cycle clear request and then moves the index
// down by one, stopping at zero.
module brick_row_tracker #(
   parameter int W     = 10,
   parameter int ROWS  = 4,
   parameter int ROW_W = 2,
   parameter int MID   = 320
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   input  logic [W-1:0]     hit_x,
   output logic             req,
   output logic [ROW_W-1:0] row,
   output logic             half
);
   localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(ROWS - 1);
   localparam logic [ROW_W-1:0] ONE     = ROW_W'(1);
   localparam logic [W-1:0]     MID_V   = W'(MID);

   logic [ROW_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= TOP_ROW;
         req   <= 1'b0;
         row   <= '0;
         half  <= 1'b0;
      end else begin
         req <= hit;
         if (hit) begin
            row   <= ptr_q;
            half  <= (hit_x >= MID_V);
            ptr_q <= (ptr_q != '0) ? ptr_q - ONE : '0;
         end
      end
   end
endmodule

// File: rtl/paddle_contact.sv
`timescale 1ns/1ps
// Tests whether the ball x lies inside the paddle span, both ends included.
module paddle_contact #(
   parameter int W   = 10,
   parameter int LEN = 50
) (
   input  logic [W-1:0] paddle_x,
   input  logic [W-1:0] ball_x,
   output logic         contact
);
   localparam logic [W:0] LEN_V = (W+1)'(LEN);

   logic [W:0] span_hi;
   logic [W:0] bx_ext;

   always_comb begin
      span_hi = {1'b0, paddle_x} + LEN_V;
      bx_ext  = {1'b0, ball_x};
      contact = (ball_x >= paddle_x) && (bx_ext <= span_hi);
   end
endmodule

// File: rtl/bounce_engine.sv
`timescale 1ns/1ps
module bounce_engine #(
   parameter int COORD_W  = 10,
   parameter int FIELD_W  = 640,
   parameter int FIELD_H  = 480,
   parameter int BALL_SZ  = 5,
   parameter int PAD_LEN  = 50,
   parameter int PAD_TOP  = 450,
   parameter int NUM_ROWS = 4,
   localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               frame_tick,
   input  logic [COORD_W-1:0] paddle_x,
   input  logic               start_btn,
   output logic [COORD_W-1:0] ball_x,
   output logic [COORD_W-1:0] ball_y,
   output logic [COORD_W-1:0] paddle_pos,
   output logic               clr_req,
   output logic [ROW_W-1:0]   clr_row,
   output logic               clr_half,
   output logic               game_over
);
   import bounce_pkg::*;

   localparam int X_CEIL  = FIELD_W - BALL_SZ;
   localparam int PARK_Y  = PAD_TOP - BALL_SZ;
   localparam int MID_X   = FIELD_W / 2;
   localparam int PAD_MID = PAD_LEN / 2;
   localparam logic [COORD_W-1:0] PARK_Y_V  = COORD_W'(PARK_Y);
   localparam logic [COORD_W-1:0] PAD_MID_V = COORD_W'(PAD_MID);

   initial begin : elab_checks
      assert (FIELD_W < (1 << COORD_W)) else $error("COORD_W too narrow for FIELD_W");
      assert (FIELD_H < (1 << COORD_W)) else $error("COORD_W too narrow for FIELD_H");
      assert (PAD_TOP + BALL_SZ <= FIELD_H) else $error("paddle row outside field");
      assert (PAD_LEN >= 2 && BALL_SZ >= 1) else $error("bad object size");
      assert (NUM_ROWS >= 1) else $error("NUM_ROWS must be positive");
   end

   phase_t phase_q;
   logic run, idle;
   logic dir_x, dir_y;
   logic live_tick, falling_low, contact, miss;
   logic x_step, y_step, y_park, top_hit;
   logic [COORD_W-1:0] load_x;

   always_comb begin
      run         = (phase_q == ST_RUN);
      idle        = (phase_q == ST_IDLE);
      load_x      = paddle_x + PAD_MID_V;
      live_tick   = run && frame_tick;
      falling_low = dir_y && (ball_y >= PARK_Y_V);
      miss        = live_tick && falling_low && !contact;
      x_step      = live_tick && !miss;
      y_step      = live_tick && !falling_low;
      y_park      = live_tick && falling_low && contact;
      top_hit     = live_tick && (ball_y == '0);
      game_over   = (phase_q == ST_OVER);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= ST_IDLE;
      end else begin
         case (phase_q)
            ST_IDLE: if (start_btn) phase_q <= ST_RUN;
            ST_RUN:  if (miss)      phase_q <= ST_OVER;
            default: phase_q <= phase_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) paddle_pos <= '0;
      else     paddle_pos <= paddle_x;
   end

   bounce_axis #(
      .W(COORD_W), .HAS_CEIL(1'b1), .CEIL(X_CEIL), .FLOOR(1),
      .PARK(0), .PARK_DIR(1'b0), .RST_POS(0), .RST_DIR(1'b1)
   ) u_xaxis (
      .clk(clk), .rst(rst), .load(idle), .load_pos(load_x), .load_dir(1'b1),
      .park(1'b0), .step(x_step), .pos(ball_x), .dir(dir_x)
   );

   bounce_axis #(
      .W(COORD_W), .HAS_CEIL(1'b0), .CEIL(0), .FLOOR(1),
      .PARK(PARK_Y), .PARK_DIR(1'b0), .RST_POS(PARK_Y), .RST_DIR(1'b0)
   ) u_yaxis (
      .clk(clk), .rst(rst), .load(idle), .load_pos(PARK_Y_V), .load_dir(1'b0),
      .park(y_park), .step(y_step), .pos(ball_y), .dir(dir_y)
   );

   paddle_contact #(.W(COORD_W), .LEN(PAD_LEN)) u_contact (
      .paddle_x(paddle_x), .ball_x(ball_x), .contact(contact)
   );

   brick_row_tracker #(.W(COORD_W), .ROWS(NUM_ROWS), .ROW_W(ROW_W), .MID(MID_X)) u_bricks (
      .clk(clk), .rst(rst), .hit(top_hit), .hit_x(ball_x),
      .req(clr_req), .row(clr_row), .half(clr_half)
   );
endmodule

// File: rtl/bounce_engine_chk.sv
`timescale 1ns/1ps
module bounce_engine_chk #(
   parameter int COORD_W = 10,
   parameter int X_LIMIT = 636,
   parameter int REST_Y  = 445
) (
   input logic               clk,
   input logic               rst,
   input logic               frame_tick,
   input logic               running,
   input logic               dir_x,
   input logic [COORD_W-1:0] ball_x,
   input logic [COORD_W-1:0] ball_y,
   input logic               clr_req,
   input logic               game_over
);
   localparam logic [COORD_W-1:0] ONE     = COORD_W'(1);
   localparam logic [COORD_W-1:0] LIMIT_V = COORD_W'(X_LIMIT);
   localparam logic [COORD_W-1:0] REST_V  = COORD_W'(REST_Y);

   assert_clr_single_R7: assert property (@(posedge clk) disable iff (rst)
      clr_req |=> !clr_req);

   assert_clr_after_top_R6: assert property (@(posedge clk) disable iff (rst)
      clr_req |-> ball_y == ONE);

   assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      game_over |=> game_over && $stable(ball_x) && $stable(ball_y));

   assert_still_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
      running && !frame_tick |=> $stable(ball_x) && $stable(ball_y));

   assert_step_follows_dir_R4: assert property (@(posedge clk) disable iff (rst)
      running && frame_tick |=> game_over ||
         (dir_x ? (ball_x == $past(ball_x) + ONE) : (ball_x == $past(ball_x) - ONE)));

   assert_idle_rest_R2: assert property (@(posedge clk) disable iff (rst)
      !running && !game_over |-> ball_y == REST_V);

   assert_x_bound_R5: assert property (@(posedge clk) disable iff (rst)
      running |-> ball_x <= LIMIT_V);
endmodule

bind bounce_engine bounce_engine_chk #(
   .COORD_W(COORD_W), .X_LIMIT(X_CEIL + 1), .REST_Y(PARK_Y)
) u_chk (
   .clk(clk), .rst(rst), .frame_tick(frame_tick), .running(run), .dir_x(dir_x),
   .ball_x(ball_x), .ball_y(ball_y), .clr_req(clr_req), .game_over(game_over)
);

// File: tb/sim_bounce_engine.sv
`timescale 1ns/1ps
module sim_bounce_engine;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_tick = 1'b0;
   logic [9:0] paddle_x = 10'd100;
   logic       start_btn = 1'b0;
   logic [9:0] ball_x, ball_y, paddle_pos;
   logic       clr_req, clr_half, game_over;
   logic [1:0] clr_row;

   always #10 clk = ~clk;

   bounce_engine u0 (
      .clk(clk), .rst(rst), .frame_tick(frame_tick), .paddle_x(paddle_x),
      .start_btn(start_btn), .ball_x(ball_x), .ball_y(ball_y),
      .paddle_pos(paddle_pos), .clr_req(clr_req), .clr_row(clr_row),
      .clr_half(clr_half), .game_over(game_over)
   );

   typedef struct packed {
      logic [9:0] x;
      logic [9:0] y;
      logic       clr;
      logic [1:0] row;
      logic       half;
      logic       go;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   event  ev_out;

   int n_chk = 0, n_bad = 0;
   int m_run, m_go, m_x, m_y, m_dx, m_dy, m_row, m_p, m_first, hits, tops;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   function automatic int pick_paddle(input int mode, input int ex, input int cur);
      int p;
      case (mode)
         0: p = (ex < 25) ? 0 : ex - 25;     // centred
         1: p = (ex >= 50) ? ex - 50 : 0;    // ball at right end of paddle
         2: p = ex;                          // ball at left end of paddle
         3: p = (ex >= 51) ? ex - 51 : ex + 1; // one pixel outside
         default: p = cur;
      endcase
      if (p > 590) p = 590;
      return p;
   endfunction

   task automatic model_reset();
      m_run = 0; m_go = 0; m_row = 3; m_dx = 1; m_dy = 0; m_first = 0;
   endtask

   // driver: chooses the paddle, predicts the outcome of one tick, queues it, pulses the tick
   task automatic do_tick(input int mode);
      string tag;
      exp_t  e;
      int    ndx, ndy;
      bit    hold, miss, clr, chalf;
      int    crow;
      @(negedge clk);
      chk(clr_req == 1'b0, "R7", "clr_req between ticks", clr_req, 0);
      m_p = pick_paddle(mode, m_x, m_p);
      paddle_x = 10'(m_p);
      tag = "R4"; clr = 0; crow = 0; chalf = 0; hold = 0; miss = 0;
      if (m_run == 0) begin
         m_x = m_p + 25; m_y = 445; tag = "R2";
      end else if (m_go != 0) begin
         tag = "R9";
      end else begin
         ndx = m_dx; ndy = m_dy;
         if (m_x > 635) begin ndx = 0; tag = "R5"; end
         else if (m_x < 1) begin ndx = 1; tag = "R5"; end
         if (m_y == 0) begin
            ndy = 1; clr = 1; crow = m_row; chalf = (m_x >= 320);
            m_row = (m_row > 0) ? m_row - 1 : 0;
            tag = "R7"; tops++;
         end
         if (m_dy == 1 && m_y >= 445) begin
            if (m_x >= m_p && m_x <= m_p + 50) begin
               ndy = 0; hold = 1; tag = "R8"; hits++;
            end else begin
               miss = 1; tag = "R9";
            end
         end
         if (miss) m_go = 1;
         else begin
            m_x = ndx ? m_x + 1 : m_x - 1;
            m_y = hold ? 445 : (ndy ? m_y + 1 : m_y - 1);
            m_dx = ndx; m_dy = ndy;
         end
         if (m_first != 0) begin tag = "R3"; m_first = 0; end
      end
      e.x = 10'(m_x); e.y = 10'(m_y); e.clr = clr; e.row = 2'(crow);
      e.half = chalf; e.go = m_go[0];
      exp_q.push_back(e);
      tag_q.push_back(tag);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      ->ev_out;
   endtask

   // monitor: pops the prediction and compares once the tick has been registered
   initial begin : monitor
      exp_t  e;
      string t;
      forever begin
         @(ev_out);
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(ball_x == e.x, t, "ball_x", ball_x, e.x);
         chk(ball_y == e.y, t, "ball_y", ball_y, e.y);
         chk(game_over == e.go, t, "game_over", game_over, e.go);
         chk(clr_req == e.clr, t, "clr_req", clr_req, e.clr);
         if (e.clr) begin
            chk(clr_row == e.row, t, "clr_row", clr_row, e.row);
            chk(clr_half == e.half, t, "clr_half", clr_half, e.half);
         end
      end
   end

   task automatic press_start();
      @(negedge clk); start_btn = 1'b1;
      @(negedge clk); start_btn = 1'b0;
      m_run = 1; m_dx = 1; m_dy = 0; m_x = m_p + 25; m_y = 445; m_first = 1;
      chk(ball_x == 10'(m_x) && ball_y == 10'd445, "R3", "ball at launch", ball_x, m_x);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      @(negedge clk); rst = 1'b0;
      model_reset();
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      hits = 0; tops = 0; m_p = 100; m_x = 125; m_y = 445;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(game_over == 1'b0, "R1", "game_over", game_over, 0);
      chk(clr_req == 1'b0, "R1", "clr_req", clr_req, 0);
      chk(ball_x == 10'd125, "R1", "ball_x", ball_x, 125);
      chk(ball_y == 10'd445, "R1", "ball_y", ball_y, 445);
      // R2: idle tracking and registered paddle output
      paddle_x = 10'd300; m_p = 300;
      @(negedge clk);
      chk(ball_x == 10'd325, "R2", "ball_x tracks paddle", ball_x, 325);
      chk(paddle_pos == 10'd300, "R2", "paddle_pos", paddle_pos, 300);
      m_p = 200;
      do_tick(4);
      do_tick(4);
      // R3: launch
      press_start();
      // R4..R8: long rally with the paddle placed centred or at either edge
      for (int i = 0; i < 5000; i++) do_tick(hits % 3);
      chk(tops >= 5, "R7", "top hits reached saturation", tops, 5);
      chk(hits >= 3, "R8", "paddle hits", hits, 3);
      // R9: paddle one pixel outside the ball
      for (int i = 0; i < 2000 && m_go == 0; i++) do_tick(3);
      chk(m_go == 1, "R9", "miss reached", m_go, 1);
      @(negedge clk); start_btn = 1'b1;
      @(negedge clk); start_btn = 1'b0;
      for (int i = 0; i < 3; i++) do_tick(4);
      // R10: reset out of game over and play again
      do_reset();
      chk(game_over == 1'b0, "R10", "game_over after reset", game_over, 0);
      chk(ball_y == 10'd445, "R10", "ball_y after reset", ball_y, 445);
      chk(ball_x == 10'(m_p + 25), "R10", "ball_x after reset", ball_x, m_p + 25);
      press_start();
      for (int i = 0; i < 20; i++) do_tick(0);
      chk(game_over == 1'b0 && ball_y == 10'd425, "R10", "replay ball_y", ball_y, 425);
      @(negedge clk);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule